// File: doc/BRIEF.md
# Overclock Watchdog with Safe Frequency Fallback

This block supervises a programmable clock source that software may push past its stable range. Once armed, it counts elapsed time in units built from a timebase tick input. Software shows that the system is still alive by writing either of the block's two registers, and each such write restarts the timeout. If the timeout runs out, the block does three things. It latches an alarm flag. It swaps the active frequency select code for a stored safe code that uses the same encoding as the frequency table. It drives an active-low system reset pulse.

The same reset pulse is produced whenever the active frequency selection changes. That covers a change of the table code, a change of the source select, and an update of the direct divider values while the direct source is in use. Events that arrive while a pulse is already under way are merged into that pulse.

The alarm holds until software writes the flag back to zero. Clearing it restores the normal selection, and that change in turn produces one reset pulse. The register-file access path, the PLL and the dividers lie outside this block.

Top module: `ovc_watchdog`

## Requirements
- R1: After reset, the count register reads DEF_COUNT (16), the control register reads 0x00, rst_n_o is 1, src_direct_o is 0 and fsel_o equals hw_fsel_i.
- R2: With enable set and no alarm, the alarm flag sets on tick number count×UNIT_TICKS after the most recent reload. A count of 0 behaves as 1.
- R3: Every register write (wr_sel_i=0: count register, wr_sel_i=1: control register) reloads the timeout, using the newly written count when the count register is the target.
- R4: While enable (control bit 6) is 0, the timeout counter holds its value and no alarm can occur, however many ticks arrive.
- R5: During an alarm, control bit 5 reads 1, fsel_o equals the safe code held in control bits 4:0, and src_direct_o is forced to 0.
- R6: The alarm is sticky. Writing 1 to bit 5 never sets it, and it stays set until a write puts 0 in bit 5. Clearing it returns fsel_o to hw_fsel_i. While the alarm is set, the timer is stopped.
- R7: Control bit 7 selects the frequency source. src_direct_o follows it when there is no alarm.
- R8: On expiry, rst_n_o goes low in the cycle after the expiring tick and stays low for RST_TICKS further ticks.
- R9: A change of the active selection (fsel_o or src_direct_o) starts a reset pulse one cycle later.
- R10: A div_upd_i pulse starts a reset pulse while src_direct_o is 1. It is ignored while src_direct_o is 0.
- R11: Events that arrive while rst_n_o is low are merged into the current pulse, so each event yields at most one pulse and the pulse is not stretched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle timebase tick |
| wr_en_i | input | 1 | Register write strobe; also services the watchdog |
| wr_sel_i | input | 1 | Write target: 0 = count register, 1 = control register |
| wr_data_i | input | 8 | Write data |
| hw_fsel_i | input | 5 | Hardware/table frequency select code |
| div_upd_i | input | 1 | Pulse: direct divider values were reprogrammed |
| fsel_o | output | 5 | Active frequency select code |
| src_direct_o | output | 1 | 1 = direct divider source, 0 = table source |
| rst_n_o | output | 1 | Active-low system reset pulse |
| count_rd_o | output | 8 | Count register contents |
| ctrl_rd_o | output | 8 | Control register: [7] source, [6] enable, [5] alarm, [4:0] safe code |

## Verification
The bench builds the block with UNIT_TICKS=3 and RST_TICKS=2, and keeps DEF_COUNT at its default of 16. With three ticks per count unit, an expiry falls within a handful of ticks. That short window lets the bench reach prescaler wrap, multi-unit counts, the count-of-zero case and the exact expiring tick. With a two-tick reset pulse, the bench can observe both the pulse edges and the merging of a follow-on selection change.

// File: rtl/ovc_wdt_pkg.sv
package ovc_wdt_pkg;

    localparam int CNT_W  = 8;
    localparam int CODE_W = 5;

    typedef enum logic {
        SEL_COUNT = 1'b0,
        SEL_CTRL  = 1'b1
    } reg_sel_e;

    // control register: [7] direct source, [6] enable, [5] alarm, [4:0] safe code
    typedef struct packed {
        logic              direct;
        logic              enable;
        logic              alarm;
        logic [CODE_W-1:0] safe;
    } ctrl_t;

    typedef struct packed {
        logic              direct;
        logic [CODE_W-1:0] code;
    } fsel_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // software may only clear the alarm flag, never set it
    function automatic ctrl_t ctrl_write(ctrl_t cur, logic [CTRL_W-1:0] d);
        ctrl_t n;
        n       = ctrl_t'(d);
        n.alarm = cur.alarm & d[CODE_W];
        return n;
    endfunction

endpackage

// File: rtl/ovc_wdt_regs.sv
module ovc_wdt_regs
    import ovc_wdt_pkg::*;
#(
    parameter int DEF_COUNT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  reg_sel_e          wr_sel_i,
    input  logic [CTRL_W-1:0] wr_data_i,
    input  logic              expire_i,
    output logic [CNT_W-1:0]  count_o,
    output ctrl_t             ctrl_o,
    output logic              reload_o,
    output logic [CNT_W-1:0]  reload_val_o
);

    logic [CNT_W-1:0] count_q;
    ctrl_t            ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= CNT_W'(DEF_COUNT);
            ctrl_q  <= '0;
        end else begin
            if (wr_en_i && wr_sel_i == SEL_COUNT)
                count_q <= wr_data_i;
            if (wr_en_i && wr_sel_i == SEL_CTRL)
                ctrl_q <= ctrl_write(ctrl_q, wr_data_i);
            else if (expire_i)
                ctrl_q.alarm <= 1'b1;
        end
    end

    assign count_o      = count_q;
    assign ctrl_o       = ctrl_q;
    assign reload_o     = wr_en_i;
    assign reload_val_o = (wr_sel_i == SEL_COUNT) ? wr_data_i : count_q;

    // R2 R6
    alarm_only_on_expiry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_q.alarm) |-> $past(expire_i));

endmodule

// File: rtl/ovc_wdt_timer.sv
module ovc_wdt_timer
    import ovc_wdt_pkg::*;
#(
    parameter int DEF_COUNT  = 16,
    parameter int UNIT_TICKS = 290
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             reload_i,
    input  logic [CNT_W-1:0] reload_val_i,
    output logic             expire_o
);

    logic [CNT_W-1:0] units_q;
    logic             unit_end;

    generate
        if (UNIT_TICKS == 1) begin : g_no_presc
            assign unit_end = 1'b1;
        end else begin : g_presc
            localparam int SUB_W = $clog2(UNIT_TICKS);
            logic [SUB_W-1:0] sub_q;
            assign unit_end = (sub_q == SUB_W'(UNIT_TICKS - 1));
            always_ff @(posedge clk) begin
                if (rst || reload_i)
                    sub_q <= '0;
                else if (tick_i && run_i)
                    sub_q <= unit_end ? '0 : sub_q + SUB_W'(1);
            end
        end
    endgenerate

    assign expire_o = tick_i && run_i && !reload_i && unit_end
                      && (units_q <= CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst)
            units_q <= CNT_W'(DEF_COUNT);
        else if (reload_i)
            units_q <= reload_val_i;
        else if (tick_i && run_i && unit_end)
            units_q <= (units_q > CNT_W'(1)) ? units_q - CNT_W'(1) : '0;
    end

    // R3
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        reload_i |=> units_q == $past(reload_val_i));

    // R4
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !reload_i) |=> $stable(units_q));

endmodule

// File: rtl/ovc_wdt_rstpulse.sv
module ovc_wdt_rstpulse
    import ovc_wdt_pkg::*;
#(
    parameter int RST_TICKS = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick_i,
    input  logic  expire_i,
    input  logic  div_upd_i,
    input  fsel_t sel_i,
    output logic  rst_n_o
);

    localparam int PC_W = (RST_TICKS > 1) ? $clog2(RST_TICKS) : 1;

    fsel_t            prev_q;
    logic             active_q;
    logic [PC_W-1:0]  pcnt_q;
    logic             event_w;

    assign event_w = expire_i || (sel_i != prev_q) || (div_upd_i && sel_i.direct);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= sel_i;
            active_q <= 1'b0;
            pcnt_q   <= '0;
        end else begin
            prev_q <= sel_i;
            if (!active_q) begin
                if (event_w) begin
                    active_q <= 1'b1;
                    pcnt_q   <= '0;
                end
            end else if (tick_i) begin
                if (pcnt_q == PC_W'(RST_TICKS - 1))
                    active_q <= 1'b0;
                else
                    pcnt_q <= pcnt_q + PC_W'(1);
            end
        end
    end

    assign rst_n_o = ~active_q;

    // R8
    release_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(active_q) |-> $past(tick_i));

    // R9 R10
    event_starts_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (event_w && !active_q) |=> !rst_n_o);

endmodule

// File: rtl/ovc_watchdog.sv
module ovc_watchdog
    import ovc_wdt_pkg::*;
#(
    parameter int DEF_COUNT  = 16,
    parameter int UNIT_TICKS = 290,
    parameter int RST_TICKS  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [CTRL_W-1:0] wr_data_i,
    input  logic [CODE_W-1:0] hw_fsel_i,
    input  logic              div_upd_i,
    output logic [CODE_W-1:0] fsel_o,
    output logic              src_direct_o,
    output logic              rst_n_o,
    output logic [CNT_W-1:0]  count_rd_o,
    output logic [CTRL_W-1:0] ctrl_rd_o
);

    ctrl_t            ctrl;
    logic             reload;
    logic [CNT_W-1:0] reload_val;
    logic             expire;
    logic             run;
    fsel_t            active_sel;

    ovc_wdt_regs #(.DEF_COUNT(DEF_COUNT)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .wr_en_i      (wr_en_i),
        .wr_sel_i     (reg_sel_e'(wr_sel_i)),
        .wr_data_i    (wr_data_i),
        .expire_i     (expire),
        .count_o      (count_rd_o),
        .ctrl_o       (ctrl),
        .reload_o     (reload),
        .reload_val_o (reload_val)
    );

    assign run = ctrl.enable && !ctrl.alarm;

    ovc_wdt_timer #(.DEF_COUNT(DEF_COUNT), .UNIT_TICKS(UNIT_TICKS)) u_timer (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick_i),
        .run_i        (run),
        .reload_i     (reload),
        .reload_val_i (reload_val),
        .expire_o     (expire)
    );

    assign active_sel.direct = ctrl.direct && !ctrl.alarm;
    assign active_sel.code   = ctrl.alarm ? ctrl.safe : hw_fsel_i;

    ovc_wdt_rstpulse #(.RST_TICKS(RST_TICKS)) u_pulse (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick_i),
        .expire_i  (expire),
        .div_upd_i (div_upd_i),
        .sel_i     (active_sel),
        .rst_n_o   (rst_n_o)
    );

    assign fsel_o       = active_sel.code;
    assign src_direct_o = active_sel.direct;
    assign ctrl_rd_o    = ctrl;

    // R8
    alarm_with_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl.alarm) |-> !rst_n_o);

endmodule

// File: tb/tb_ovc_watchdog.sv
module tb_ovc_watchdog;

    localparam int UT = 3;
    localparam int RT = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic [4:0] hw = 5'd9;
    logic       div_upd = 1'b0;
    logic [4:0] fsel;
    logic       src_direct;
    logic       rst_n;
    logic [7:0] count_rd;
    logic [7:0] ctrl_rd;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ovc_watchdog #(.UNIT_TICKS(UT), .RST_TICKS(RT)) dut (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick),
        .wr_en_i      (wr_en),
        .wr_sel_i     (wr_sel),
        .wr_data_i    (wr_data),
        .hw_fsel_i    (hw),
        .div_upd_i    (div_upd),
        .fsel_o       (fsel),
        .src_direct_o (src_direct),
        .rst_n_o      (rst_n),
        .count_rd_o   (count_rd),
        .ctrl_rd_o    (ctrl_rd)
    );

    typedef struct packed {
        logic [7:0] cnt;
        logic [4:0] safe;
        logic [4:0] hw;
        logic [7:0] nt;
        logic       alarm;
        logic [4:0] fsel;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{8'd2, 5'd5,  5'd9,  8'd5, 1'b0, 5'd9},
        '{8'd2, 5'd5,  5'd9,  8'd6, 1'b1, 5'd5},
        '{8'd1, 5'd31, 5'd0,  8'd3, 1'b1, 5'd31},
        '{8'd0, 5'd7,  5'd3,  8'd2, 1'b0, 5'd3},
        '{8'd0, 5'd7,  5'd3,  8'd3, 1'b1, 5'd7},
        '{8'd3, 5'd0,  5'd12, 8'd9, 1'b1, 5'd0},
        '{8'd3, 5'd0,  5'd12, 8'd8, 1'b0, 5'd12}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        // R1 reset state
        chk("R1 count", count_rd, 16);
        chk("R1 ctrl", ctrl_rd, 0);
        chk("R1 rst_n", rst_n, 1);
        chk("R1 fsel", fsel, 9);
        chk("R1 src", src_direct, 0);

        // R2 R5 vector walk
        for (int k = 0; k < 7; k++) begin
            hw = VECS[k].hw;
            idle(1);
            wr(1'b0, VECS[k].cnt);
            wr(1'b1, {3'b010, VECS[k].safe});
            ticks(int'(VECS[k].nt));
            chk("R2 alarm", ctrl_rd[5], VECS[k].alarm);
            chk("R5 fsel", fsel, VECS[k].fsel);
            wr(1'b1, 8'h00);
            ticks(RT);
            idle(1);
        end

        // R4 disabled: no alarm
        hw = 5'd9;
        ticks(60);
        chk("R4 alarm", ctrl_rd[5], 0);
        chk("R4 rst_n", rst_n, 1);

        // R3 servicing by either register
        wr(1'b0, 8'd2);
        wr(1'b1, 8'h43);
        ticks(5);
        wr(1'b0, 8'd2);
        ticks(5);
        chk("R3 count write", ctrl_rd[5], 0);
        wr(1'b1, 8'h43);
        ticks(5);
        chk("R3 ctrl write", ctrl_rd[5], 0);
        ticks(1);
        chk("R2 expiry", ctrl_rd[5], 1);
        chk("R5 safe code", fsel, 3);
        // R8 pulse width
        chk("R8 low", rst_n, 0);
        idle(3);
        chk("R8 low between ticks", rst_n, 0);
        ticks(1);
        chk("R8 low", rst_n, 0);
        ticks(1);
        chk("R11 merged release", rst_n, 1);
        ticks(20);
        chk("R6 timer stopped", rst_n, 1);
        chk("R6 alarm held", ctrl_rd[5], 1);

        // R6 sticky and clear
        wr(1'b1, 8'h63);
        chk("R6 kept by 1", ctrl_rd[5], 1);
        wr(1'b1, 8'h03);
        chk("R6 cleared", ctrl_rd[5], 0);
        chk("R6 fsel restored", fsel, 9);
        idle(1);
        chk("R9 pulse on clear", rst_n, 0);
        ticks(RT);
        chk("R9 released", rst_n, 1);
        wr(1'b1, 8'h23);
        chk("R6 write 1 no set", ctrl_rd, 8'h03);

        // R7 R10 source select
        wr(1'b1, 8'h80);
        chk("R7 src", src_direct, 1);
        idle(1);
        chk("R9 src change", rst_n, 0);
        ticks(RT);
        chk("R9 released", rst_n, 1);
        @(negedge clk); div_upd = 1'b1;
        @(negedge clk); div_upd = 1'b0;
        chk("R10 div update", rst_n, 0);
        ticks(RT);
        wr(1'b1, 8'h00);
        idle(1);
        ticks(RT);
        chk("R7 src off", src_direct, 0);
        @(negedge clk); div_upd = 1'b1;
        @(negedge clk); div_upd = 1'b0;
        chk("R10 ignored", rst_n, 1);
        idle(2);
        chk("R10 ignored", rst_n, 1);

        // R9 table code change
        @(negedge clk); hw = 5'd20;
        @(negedge clk);
        chk("R9 hw change", rst_n, 0);
        ticks(RT);
        chk("R9 released", rst_n, 1);

        // R5 source forced off in alarm
        wr(1'b0, 8'd1);
        wr(1'b1, 8'hD1);
        ticks(3);
        chk("R5 alarm", ctrl_rd[5], 1);
        chk("R5 src forced", src_direct, 0);
        chk("R5 safe code", fsel, 17);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule